// File: doc/BRIEF.md
# Sequential Signed 16x16 Multiplier

This unit forms the full 32-bit two's-complement product of two 16-bit operands for a small coprocessor. It owns a single unsigned 8x8 multiplier and sends one pair of operand bytes through it on each pass. After four passes it has covered all four byte pairings and summed them into a 32-bit accumulator. A sign correction then turns this unsigned sum into the exact signed product.

The result is split in two. The upper half goes to the destination register that the surrounding core selects. The lower half goes to a fixed auxiliary register whose index is a parameter. Because the upper half has its own port, a fractional-multiply path can reuse it.

A configuration bit chooses between a fast schedule and a slow schedule. In the slow schedule each pass is stretched by one wait cycle. On completion the unit raises:
- a one-cycle done strobe,
- sign, carry and zero flags,
- a request to clear the core's prefix state.

It also flags when the destination select collides with the low-word register index, because the core's result is undefined in that case. The overflow flag of the core is not driven by this unit.

Top module: `smul16_seq`

## Requirements
- R1: When done is high, {prod_hi, prod_lo} equals the signed 32-bit product of the operands accepted with the start; for example, 0xB556 times 0xDAAB gives prod_hi 0x0AE3 and prod_lo 0x5C72.
- R2: The product is exact at the range limits; for example, 0x8000 times 0x8000 gives prod_hi 0x4000 and prod_lo 0x0000.
- R3: With slow_mode low at the accepted start, done rises 5 clock edges after the edge that accepted start.
- R4: With slow_mode high at the accepted start, done rises 9 clock edges after the edge that accepted start.
- R5: Flag values when done is high:
  - flag_s equals bit 15 of prod_hi.
  - flag_z is 1 exactly when prod_hi is 0x0000.
  - flag_cy equals bit 15 of prod_lo.
- R6: done is high for exactly one cycle per operation. busy is high from the cycle after an accepted start until done rises, and busy is low while done is high.
- R7: A start that arrives while busy is high is ignored, and a later result reflects only the operands that were accepted.
- R8: dst_clash is 1 alongside done exactly when dst_sel, sampled with the accepted start, equals the low-word register index (default 4).
- R9: prefix_clr pulses high in the same cycle as done.
- R10: After reset, the result outputs and flags are 0. Between completions they hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_a | input | 16 | First signed operand (source register value) |
| op_b | input | 16 | Second signed operand (fixed factor register value) |
| slow_mode | input | 1 | 1 selects the stretched schedule |
| dst_sel | input | 4 | Index of the destination register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| prod_hi | output | 16 | Upper product half, for the destination register |
| prod_lo | output | 16 | Lower product half, for the fixed auxiliary register |
| flag_s | output | 1 | Sign flag |
| flag_cy | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| dst_clash | output | 1 | Destination index equals the low-word register index |
| prefix_clr | output | 1 | Request to clear prefix state |

## Verification
The unit can see a new start in the same cycle as it finishes. There are two such cycles: the finishing cycle, when busy is still high, and the cycle in which done is high. The bench holds start high across long stretches and also pulses it in the middle of an operation, so both cycles are hit. A cycle-accurate reference model decides acceptance from its own idea of busy before each edge. Every cycle it compares done, busy and the results. A start in the finishing cycle must be dropped; a start while done is high must be taken.

// File: rtl/smul_pkg.sv
package smul_pkg;

    localparam int DATA_W  = 16;
    localparam int SLICE_W = 8;
    localparam int NSLICE  = DATA_W / SLICE_W;
    localparam int NPASS   = NSLICE * NSLICE;
    localparam int PASS_W  = (NPASS > 1) ? $clog2(NPASS) : 1;
    localparam int PROD_W  = 2 * DATA_W;
    localparam int PP_W    = 2 * SLICE_W;

    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [PROD_W-1:0]  prod_t;
    typedef logic [SLICE_W-1:0] slice_t;
    typedef logic [PP_W-1:0]    pp_t;
    typedef logic [PASS_W-1:0]  pass_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } mstate_e;

    typedef struct packed {
        word_t hi;
        word_t lo;
        logic  s;
        logic  cy;
        logic  z;
        logic  clash;
    } mres_t;

    // Byte index of operand A for a given pass
    function automatic int a_slice(pass_t idx);
        return int'(idx) % NSLICE;
    endfunction

    // Byte index of operand B for a given pass
    function automatic int b_slice(pass_t idx);
        return int'(idx) / NSLICE;
    endfunction

    // Place a partial product at its weight
    function automatic prod_t place_pp(pp_t pp, pass_t idx);
        int sh;
        sh = (a_slice(idx) + b_slice(idx)) * SLICE_W;
        return prod_t'(pp) << sh;
    endfunction

    // Turn the unsigned product sum into the signed product (mod 2^PROD_W)
    function automatic prod_t sign_fix(prod_t raw, word_t a, word_t b);
        prod_t r;
        r = raw;
        if (a[DATA_W-1]) r = r - {b, {DATA_W{1'b0}}};
        if (b[DATA_W-1]) r = r - {a, {DATA_W{1'b0}}};
        return r;
    endfunction

    function automatic mres_t make_result(prod_t p, logic clash);
        mres_t r;
        r.hi    = p[PROD_W-1:DATA_W];
        r.lo    = p[DATA_W-1:0];
        r.s     = p[PROD_W-1];
        r.cy    = p[DATA_W-1];
        r.z     = (p[PROD_W-1:DATA_W] == '0);
        r.clash = clash;
        return r;
    endfunction

endpackage

// File: rtl/smul_mul8.sv
module smul_mul8
    import smul_pkg::*;
(
    input  slice_t x,
    input  slice_t y,
    output pp_t    p
);
    assign p = pp_t'(x) * pp_t'(y);
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
#(
    parameter int SLOW_EXTRA = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  slow_mode,
    output logic  busy,
    output logic  load,
    output logic  step,
    output pass_t pass_idx,
    output logic  finish
);
    localparam int WAIT_W = (SLOW_EXTRA > 0) ? $clog2(SLOW_EXTRA + 1) : 1;
    localparam logic [WAIT_W-1:0] WAIT_SLOW = WAIT_W'(SLOW_EXTRA);

    mstate_e           state_q;
    pass_t             pass_q;
    logic [WAIT_W-1:0] wait_q;
    logic              slow_q;
    logic              pass_due;

    assign pass_due = (wait_q == (slow_q ? WAIT_SLOW : '0));
    assign busy     = (state_q != ST_IDLE);
    assign load     = (state_q == ST_IDLE) && start;
    assign step     = (state_q == ST_RUN) && pass_due;
    assign finish   = (state_q == ST_FIN);
    assign pass_idx = pass_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pass_q  <= '0;
            wait_q  <= '0;
            slow_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        pass_q  <= '0;
                        wait_q  <= '0;
                        slow_q  <= slow_mode;
                    end
                end
                ST_RUN: begin
                    if (pass_due) begin
                        wait_q <= '0;
                        if (pass_q == pass_t'(NPASS - 1)) begin
                            state_q <= ST_FIN;
                        end else begin
                            pass_q <= pass_q + 1'b1;
                        end
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/smul_acc.sv
module smul_acc
    import smul_pkg::*;
#(
    parameter int REG_IDX_W  = 4,
    parameter int LO_REG_IDX = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  word_t                a_in,
    input  word_t                b_in,
    input  logic [REG_IDX_W-1:0] dst_in,
    input  logic                 step,
    input  pass_t                pass_idx,
    input  logic                 finish,
    output mres_t                res,
    output logic                 done
);
    word_t a_q, b_q;
    prod_t acc_q;
    logic  clash_q;
    slice_t xs, ys;
    pp_t    pp;

    assign xs = a_q[a_slice(pass_idx)*SLICE_W +: SLICE_W];
    assign ys = b_q[b_slice(pass_idx)*SLICE_W +: SLICE_W];

    smul_mul8 u_mul (
        .x (xs),
        .y (ys),
        .p (pp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q     <= '0;
            b_q     <= '0;
            acc_q   <= '0;
            clash_q <= 1'b0;
            res     <= '0;
            done    <= 1'b0;
        end else begin
            done <= finish;
            if (load) begin
                a_q     <= a_in;
                b_q     <= b_in;
                acc_q   <= '0;
                clash_q <= (dst_in == REG_IDX_W'(LO_REG_IDX));
            end else if (step) begin
                acc_q <= acc_q + place_pp(pp, pass_idx);
            end
            if (finish) begin
                res <= make_result(sign_fix(acc_q, a_q, b_q), clash_q);
            end
        end
    end
endmodule

// File: rtl/smul16_seq.sv
module smul16_seq
    import smul_pkg::*;
#(
    parameter int REG_IDX_W  = 4,
    parameter int LO_REG_IDX = 4,
    parameter int SLOW_EXTRA = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [DATA_W-1:0]    op_a,
    input  logic [DATA_W-1:0]    op_b,
    input  logic                 slow_mode,
    input  logic [REG_IDX_W-1:0] dst_sel,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    prod_hi,
    output logic [DATA_W-1:0]    prod_lo,
    output logic                 flag_s,
    output logic                 flag_cy,
    output logic                 flag_z,
    output logic                 dst_clash,
    output logic                 prefix_clr
);
    logic  load, step, finish;
    pass_t pass_idx;
    mres_t res;

    smul_ctrl #(.SLOW_EXTRA(SLOW_EXTRA)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .slow_mode (slow_mode),
        .busy      (busy),
        .load      (load),
        .step      (step),
        .pass_idx  (pass_idx),
        .finish    (finish)
    );

    smul_acc #(.REG_IDX_W(REG_IDX_W), .LO_REG_IDX(LO_REG_IDX)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .a_in     (op_a),
        .b_in     (op_b),
        .dst_in   (dst_sel),
        .step     (step),
        .pass_idx (pass_idx),
        .finish   (finish),
        .res      (res),
        .done     (done)
    );

    assign prod_hi    = res.hi;
    assign prod_lo    = res.lo;
    assign flag_s     = res.s;
    assign flag_cy    = res.cy;
    assign flag_z     = res.z;
    assign dst_clash  = res.clash;
    assign prefix_clr = done;
endmodule

// File: rtl/smul16_seq_chk.sv
module smul16_seq_chk
    import smul_pkg::*;
#(
    parameter int SLOW_EXTRA = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              slow_mode,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] prod_hi,
    input logic [DATA_W-1:0] prod_lo,
    input logic              flag_z,
    input logic              prefix_clr
);
    localparam int LAT_FAST = NPASS + 1;
    localparam int LAT_SLOW = NPASS * (1 + SLOW_EXTRA) + 1;

    logic [7:0] cnt_q;
    logic       mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            mode_q <= 1'b0;
        end else if (start && !busy) begin
            cnt_q  <= '0;
            mode_q <= slow_mode;
        end else if (busy) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    p_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    p_latency_r3_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(cnt_q) == (mode_q ? LAT_SLOW : LAT_FAST)));
    p_zero_flag_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_z == (prod_hi == '0)));
    p_prefix_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> prefix_clr);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(prod_hi) && $stable(prod_lo)));
endmodule

bind smul16_seq smul16_seq_chk #(.SLOW_EXTRA(SLOW_EXTRA)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .slow_mode  (slow_mode),
    .busy       (busy),
    .done       (done),
    .prod_hi    (prod_hi),
    .prod_lo    (prod_lo),
    .flag_z     (flag_z),
    .prefix_clr (prefix_clr)
);

// File: tb/sim_smul16_seq.sv
`timescale 1ns/1ps
module sim_smul16_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic        slow_mode = 1'b0;
    logic [3:0]  dst_sel = '0;
    logic        busy, done, flag_s, flag_cy, flag_z, dst_clash, prefix_clr;
    logic [15:0] prod_hi, prod_lo;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smul16_seq u0 (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .slow_mode(slow_mode), .dst_sel(dst_sel), .busy(busy), .done(done),
        .prod_hi(prod_hi), .prod_lo(prod_lo), .flag_s(flag_s),
        .flag_cy(flag_cy), .flag_z(flag_z), .dst_clash(dst_clash),
        .prefix_clr(prefix_clr)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model state
    int          cyc = 0, due = 0;
    bit          mb = 0;
    bit          e_slow;
    logic [15:0] e_hi, e_lo, last_hi = '0, last_lo = '0;
    bit          e_clash;

    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            if (rst) begin
                mb = 0;
            end else begin
                bit old;
                old = mb;
                if (old && cyc == due) begin
                    chk(done === 1'b1, e_slow ? "R4 slow latency" : "R3 fast latency", 32'(done), 1);
                    chk(prod_hi === e_hi && prod_lo === e_lo, "R1 product",
                        {prod_hi, prod_lo}, {e_hi, e_lo});
                    chk(flag_s === e_hi[15], "R5 sign flag", 32'(flag_s), 32'(e_hi[15]));
                    chk(flag_z === (e_hi == 16'h0), "R5 zero flag", 32'(flag_z), 32'(e_hi == 16'h0));
                    chk(flag_cy === e_lo[15], "R5 carry flag", 32'(flag_cy), 32'(e_lo[15]));
                    chk(dst_clash === e_clash, "R8 clash flag", 32'(dst_clash), 32'(e_clash));
                    chk(prefix_clr === 1'b1, "R9 prefix clear", 32'(prefix_clr), 1);
                    last_hi = e_hi;
                    last_lo = e_lo;
                    mb = 0;
                end else begin
                    chk(done === 1'b0, "R6 done single pulse", 32'(done), 0);
                    chk(prefix_clr === 1'b0, "R9 prefix idle", 32'(prefix_clr), 0);
                    chk(prod_hi === last_hi && prod_lo === last_lo, "R10 hold",
                        {prod_hi, prod_lo}, {last_hi, last_lo});
                end
                if (!old && start) begin
                    longint p;
                    p = longint'($signed(op_a)) * longint'($signed(op_b));
                    e_hi    = p[31:16];
                    e_lo    = p[15:0];
                    e_slow  = slow_mode;
                    e_clash = (dst_sel == 4'd4);
                    due     = cyc + (slow_mode ? 9 : 5);
                    mb      = 1;
                end
                chk(busy === (mb && cyc != due), "R6 busy", 32'(busy), 32'(mb && cyc != due));
            end
        end
    end

    task automatic run_op(logic [15:0] a, logic [15:0] b, bit slow, logic [3:0] d);
        @(negedge clk);
        op_a = a; op_b = b; slow_mode = slow; dst_sel = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (mb) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(prod_hi === 16'h0 && prod_lo === 16'h0, "R10 reset result", {prod_hi, prod_lo}, 0);
        chk({busy, done, flag_s, flag_cy, flag_z, dst_clash} === 6'b0, "R10 reset flags",
            32'({busy, done, flag_s, flag_cy, flag_z, dst_clash}), 0);

        // R1 worked example, fast and slow
        run_op(16'hB556, 16'hDAAB, 1'b0, 4'd8);
        chk(prod_hi === 16'h0AE3 && prod_lo === 16'h5C72, "R1 example", {prod_hi, prod_lo}, 32'h0AE35C72);
        run_op(16'hB556, 16'hDAAB, 1'b1, 4'd8);

        // R2 extremes
        run_op(16'h8000, 16'h8000, 1'b0, 4'd1);
        chk(prod_hi === 16'h4000 && prod_lo === 16'h0000, "R2 min*min", {prod_hi, prod_lo}, 32'h40000000);
        run_op(16'h7FFF, 16'h8000, 1'b1, 4'd1);
        chk({prod_hi, prod_lo} === 32'hC0008000, "R2 max*min", {prod_hi, prod_lo}, 32'hC0008000);
        run_op(16'hFFFF, 16'h0001, 1'b0, 4'd2);
        run_op(16'h0000, 16'h1234, 1'b0, 4'd2);
        chk(flag_z === 1'b1, "R5 zero on zero product", 32'(flag_z), 1);

        // R8 clash on low-word register index
        run_op(16'h0123, 16'h0456, 1'b0, 4'd4);
        chk(dst_clash === 1'b1, "R8 clash set", 32'(dst_clash), 1);
        run_op(16'h0123, 16'h0456, 1'b1, 4'd5);

        // R7 start while busy ignored
        @(negedge clk);
        op_a = 16'h0003; op_b = 16'h0005; slow_mode = 1'b1; dst_sel = 4'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        op_a = 16'h1111; op_b = 16'h2222; slow_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (mb) @(negedge clk);
        @(negedge clk);
        chk({prod_hi, prod_lo} === 32'd15, "R7 busy start ignored", {prod_hi, prod_lo}, 32'd15);

        // Start held high: exercises finishing-cycle and done-cycle collisions
        @(negedge clk);
        op_a = 16'hFF9C; op_b = 16'h0321; slow_mode = 1'b0; start = 1'b1;
        repeat (30) @(negedge clk);
        slow_mode = 1'b1; op_a = 16'h7FFF; op_b = 16'h7FFF;
        repeat (40) @(negedge clk);
        start = 1'b0;
        while (mb) @(negedge clk);

        // Randomized operands in both modes
        for (int i = 0; i < 60; i++) begin
            run_op(16'($urandom), 16'($urandom), 1'($urandom), 4'($urandom));
        end

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule